// File: doc/BRIEF.md
# Guarded Pin Function Select Register

This block holds the per-pin configuration for eight package pins. For each pin it keeps three settings: an alternate-function select bit, a digital-enable bit and a pull-up bit. The alternate function routes the pin to an on-chip debug port, and clearing the bit hands the pin back to general-purpose use. The settings leave the block as parallel per-pin outputs for the pad logic. Software reaches the block over a simple synchronous register bus. The bus has a word address, 32-bit write data, a write strobe and combinational read data.

Five pin positions carry the debug port and are marked critical. These pins come out of reset with all three settings at 1, so a debugger can always attach after power-up. A write to the alternate-select bit of a critical pin only takes effect when two conditions hold. First, a lock register must have been opened by writing a 32-bit key. Second, the matching bit of a commit-enable register must be 1. This guards against stray code switching the debug pins away and locking the debugger out. The guard does not apply to non-critical bits, to the digital-enable register or to the pull-up register.

Top module: `pin_func_guard`

## Requirements
- R1: After reset, alternate-select, digital-enable and pull-up read 1 on the critical pins and 0 on all other pins. The lock register reads 1 (locked) and the commit register reads 0.
- R2: The word address map is: 0 alternate-select, 1 digital-enable, 2 pull-up, 3 lock, 4 commit. Pin n is bit n. Each register reads back its stored value, zero-extended to 32 bits. The lock register reads 1 in bit 0 when locked and 0 when unlocked.
- R3: While the block is locked, a write to the alternate-select register leaves every critical bit unchanged.
- R4: While unlocked, a critical alternate-select bit takes the written value only if its commit bit is 1. Writing 0 there returns the pin to general-purpose use. Critical bits whose commit bit is 0 keep their value.
- R5: Non-critical alternate-select bits always take the written value, whatever the lock and commit state.
- R6: Writing 0x4C4F434B to the lock register unlocks the block. Writing any other value locks it.
- R7: The commit register accepts writes only while unlocked. A write while locked leaves it unchanged.
- R8: Digital-enable and pull-up take every write in full, whatever the lock and commit state.
- R9: The critical pins are bits 0, 1, 2, 3 and 7 (mask 0x8F by default).
- R10: Writes to addresses 5 to 7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word address of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| alt_sel | output | 8 | Per-pin alternate-function select |
| dig_en | output | 8 | Per-pin digital enable |
| pull_up | output | 8 | Per-pin pull-up enable |

## Verification
The assertions are checked on every cycle. They cover the following:
- Critical alternate-select bits never move without a prior write made while unlocked and with the commit bit set.
- Non-critical bits, digital-enable and pull-up follow each write.
- The lock state after a lock write matches the key comparison.
- The commit register holds while locked.
- The outputs keep their reset pattern until the first write.

The bench scenarios show what single-cycle properties cannot. They step through a full unlock, commit, clear and relock sequence against an independently tabulated expectation. They also check register readback, a near-miss key and unmapped addresses. Finally, they confirm that a mid-run reset restores the debug-safe defaults.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_ALT    = 3'd0;
  localparam logic [ADDR_W-1:0] A_DEN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PUP    = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOCK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_COMMIT = 3'd4;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F_434B;

  // Bits of the alternate-select register that a write may change.
  function automatic logic [7:0] alt_write_mask(input logic [7:0] prot,
                                                input logic [7:0] commit,
                                                input logic       open);
    logic [7:0] gate;
    gate = prot & commit & {8{open}};
    return (~prot) | gate;
  endfunction

  // Next value of a register under a per-bit write mask.
  function automatic logic [7:0] masked_merge(input logic [7:0] old_v,
                                              input logic [7:0] new_v,
                                              input logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/pfr_lock_ctrl.sv
module pfr_lock_ctrl
  import pfr_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  logic key_match;
  assign key_match = (wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (lock_we) begin
      unlocked <= key_match;
    end
  end
endmodule

// File: rtl/pfr_field_reg.sv
module pfr_field_reg
  import pfr_pkg::*;
#(
  parameter int unsigned       W   = 8,
  parameter logic [W-1:0]      RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST;
    end else if (we) begin
      q <= masked_merge(q, wdata, wmask);
    end
  end
endmodule

// File: rtl/pfr_read_mux.sv
module pfr_read_mux
  import pfr_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  alt_q,
  input  logic [NPINS-1:0]  den_q,
  input  logic [NPINS-1:0]  pup_q,
  input  logic [NPINS-1:0]  commit_q,
  input  logic              unlocked,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - NPINS;

  always_comb begin
    unique case (addr)
      A_ALT:    rd_data = {{PAD_W{1'b0}}, alt_q};
      A_DEN:    rd_data = {{PAD_W{1'b0}}, den_q};
      A_PUP:    rd_data = {{PAD_W{1'b0}}, pup_q};
      A_LOCK:   rd_data = {{(DATA_W-1){1'b0}}, ~unlocked};
      A_COMMIT: rd_data = {{PAD_W{1'b0}}, commit_q};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pin_func_guard.sv
module pin_func_guard
  import pfr_pkg::*;
#(
  parameter int unsigned       NPINS     = 8,
  parameter logic [NPINS-1:0]  PROT_MASK = 8'h8F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [7:0]        alt_sel,
  output logic [7:0]        dig_en,
  output logic [7:0]        pull_up
);
  localparam int unsigned NREG = 3; // alt, den, pup

  logic              unlocked;
  logic [NPINS-1:0]  commit_q;
  logic [NPINS-1:0]  wr_pins;
  logic [NPINS-1:0]  alt_mask;
  logic              lock_we;
  logic              commit_we;
  logic [NREG-1:0]   pin_we;
  logic [NPINS-1:0]  pin_mask [NREG];
  logic [NPINS-1:0]  pin_q    [NREG];
  logic              prot_write_dropped; // event: a guarded bit change was refused

  assign wr_pins   = wr_data[NPINS-1:0];
  assign lock_we   = wr_en && (addr == A_LOCK);
  assign commit_we = wr_en && (addr == A_COMMIT) && unlocked;
  assign pin_we[0] = wr_en && (addr == A_ALT);
  assign pin_we[1] = wr_en && (addr == A_DEN);
  assign pin_we[2] = wr_en && (addr == A_PUP);

  assign alt_mask    = alt_write_mask(PROT_MASK, commit_q, unlocked);
  assign pin_mask[0] = alt_mask;
  assign pin_mask[1] = '1;
  assign pin_mask[2] = '1;

  assign prot_write_dropped = pin_we[0] && |(~alt_mask & (wr_pins ^ pin_q[0]));

  pfr_lock_ctrl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_we  (lock_we),
    .wdata    (wr_data),
    .unlocked (unlocked)
  );

  pfr_field_reg #(.W(NPINS), .RST('0)) u_commit (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_we),
    .wmask ({NPINS{1'b1}}),
    .wdata (wr_pins),
    .q     (commit_q)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_pinreg
    pfr_field_reg #(.W(NPINS), .RST(PROT_MASK)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pin_we[k]),
      .wmask (pin_mask[k]),
      .wdata (wr_pins),
      .q     (pin_q[k])
    );
  end

  assign alt_sel = pin_q[0];
  assign dig_en  = pin_q[1];
  assign pull_up = pin_q[2];

  pfr_read_mux #(.NPINS(NPINS)) u_rmux (
    .addr     (addr),
    .alt_q    (pin_q[0]),
    .den_q    (pin_q[1]),
    .pup_q    (pin_q[2]),
    .commit_q (commit_q),
    .unlocked (unlocked),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/pin_func_guard_chk.sv
module pin_func_guard_chk
  import pfr_pkg::*;
#(
  parameter logic [7:0] PROT = 8'h8F
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [7:0]  alt_sel,
  input logic [7:0]  dig_en,
  input logic [7:0]  pull_up,
  input logic        unlocked,
  input logic [7:0]  commit_q
);
  logic seen_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_wr <= 1'b0;
    else if (wr_en) seen_wr <= 1'b1;
  end

  logic wr_alt, wr_den, wr_pup, wr_lock, wr_commit;
  assign wr_alt    = wr_en && addr == A_ALT;
  assign wr_den    = wr_en && addr == A_DEN;
  assign wr_pup    = wr_en && addr == A_PUP;
  assign wr_lock   = wr_en && addr == A_LOCK;
  assign wr_commit = wr_en && addr == A_COMMIT;

  a_r1_reset_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr |-> (alt_sel == PROT && dig_en == PROT && pull_up == PROT
                  && !unlocked && commit_q == 8'h00));

  a_r3_locked_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alt && !unlocked) |=> ((alt_sel & PROT) == ($past(alt_sel) & PROT)));

  a_r4_commit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_alt && unlocked) |=> ((alt_sel & PROT) == ($past(alt_sel) & PROT)));

  a_r4_uncommitted_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alt |=> (((alt_sel ^ $past(alt_sel)) & PROT & ~$past(commit_q)) == 8'h00));

  a_r5_free_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alt |=> ((alt_sel & ~PROT) == ($past(wr_data[7:0]) & ~PROT)));

  a_r6_key: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |=> (unlocked == ($past(wr_data) == UNLOCK_KEY)));

  a_r7_commit_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !unlocked) |=> $stable(commit_q));

  a_r8_den_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_den |=> (dig_en == $past(wr_data[7:0])));

  a_r8_pup_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pup |=> (pull_up == $past(wr_data[7:0])));

  a_r10_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(alt_sel) && $stable(dig_en) && $stable(pull_up)
                && $stable(commit_q) && $stable(unlocked)));
endmodule

bind pin_func_guard pin_func_guard_chk #(.PROT(PROT_MASK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .alt_sel  (alt_sel),
  .dig_en   (dig_en),
  .pull_up  (pull_up),
  .unlocked (unlocked),
  .commit_q (commit_q)
);

// File: tb/pin_func_guard_tb.sv
module pin_func_guard_tb;
  localparam logic [31:0] KEY  = 32'h4C4F_434B;
  localparam logic [7:0]  PROT = 8'h8F; // R9 critical pins 0,1,2,3,7
  localparam int NV = 18;

  // {addr, wdata, expected alt_sel, dig_en, pull_up} after the write
  localparam logic [58:0] VEC [NV] = '{
    {3'd0, 32'h0000_0000, 8'h8F, 8'h8F, 8'h8F}, // R3 locked clear refused
    {3'd0, 32'h0000_00FF, 8'hFF, 8'h8F, 8'h8F}, // R5 free bits set
    {3'd4, 32'h0000_00FF, 8'hFF, 8'h8F, 8'h8F}, // R7 commit write locked
    {3'd3, KEY,           8'hFF, 8'h8F, 8'h8F}, // R6 unlock
    {3'd0, 32'h0000_0000, 8'h8F, 8'h8F, 8'h8F}, // R4 commit 0 holds
    {3'd4, 32'h0000_0003, 8'h8F, 8'h8F, 8'h8F}, // R7 commit write open
    {3'd0, 32'h0000_0000, 8'h8C, 8'h8F, 8'h8F}, // R4 committed bits clear
    {3'd1, 32'h0000_0000, 8'h8C, 8'h00, 8'h8F}, // R8 den write
    {3'd3, 32'h0000_0000, 8'h8C, 8'h00, 8'h8F}, // R6 relock
    {3'd0, 32'h0000_0000, 8'h8C, 8'h00, 8'h8F}, // R3
    {3'd2, 32'h0000_0055, 8'h8C, 8'h00, 8'h55}, // R8 pup while locked
    {3'd1, 32'h0000_00A5, 8'h8C, 8'hA5, 8'h55}, // R8 den while locked
    {3'd5, 32'hFFFF_FFFF, 8'h8C, 8'hA5, 8'h55}, // R10 unmapped write
    {3'd0, 32'h0000_00FF, 8'hFC, 8'hA5, 8'h55}, // R3 and R5
    {3'd3, KEY,           8'hFC, 8'hA5, 8'h55}, // R6
    {3'd0, 32'h0000_000F, 8'h8F, 8'hA5, 8'h55}, // R4 committed bits set
    {3'd3, 32'h4C4F_434A, 8'h8F, 8'hA5, 8'h55}, // R6 near-miss relocks
    {3'd0, 32'h0000_0000, 8'h8F, 8'hA5, 8'h55}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  alt_sel, dig_en, pull_up;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  pin_func_guard u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .alt_sel(alt_sel), .dig_en(dig_en), .pull_up(pull_up)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic check_reset_state();
    check("R1 alt", {24'h0, alt_sel}, {24'h0, PROT});
    check("R1 den", {24'h0, dig_en}, {24'h0, PROT});
    check("R1 pup", {24'h0, pull_up}, {24'h0, PROT});
    bus_read("R1 lock reads locked", 3'd3, 32'h1);
    bus_read("R1 commit zero", 3'd4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][58:56], VEC[i][55:24]);
      check($sformatf("vec%0d alt", i), {24'h0, alt_sel}, {24'h0, VEC[i][23:16]});
      check($sformatf("vec%0d den", i), {24'h0, dig_en},  {24'h0, VEC[i][15:8]});
      check($sformatf("vec%0d pup", i), {24'h0, pull_up}, {24'h0, VEC[i][7:0]});
    end

    // R2 readback map
    bus_read("R2 alt read", 3'd0, 32'h8F);
    bus_read("R2 den read", 3'd1, 32'hA5);
    bus_read("R2 pup read", 3'd2, 32'h55);
    bus_read("R2 lock read", 3'd3, 32'h1);
    bus_read("R2 commit read", 3'd4, 32'h03);
    // R10 unmapped reads
    bus_read("R10 addr5", 3'd5, 32'h0);
    bus_read("R10 addr7", 3'd7, 32'h0);
    // R7 locked commit write ignored
    bus_write(3'd4, 32'hFF);
    bus_read("R7 commit unchanged", 3'd4, 32'h03);
    // R6 unlocked read
    bus_write(3'd3, KEY);
    bus_read("R6 lock reads open", 3'd3, 32'h0);
    // R4 clear pin 7 after committing it
    bus_write(3'd4, 32'h80);
    bus_write(3'd0, 32'h0F);
    check("R4 pin7 to gpio", {24'h0, alt_sel}, 32'h0F);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_reset_state();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule